// File: doc/BRIEF.md
# Interrupt Vector Selector with Bank-Relative Timer Entries

This unit decides when the program counter of a small banked controller is redirected to a fixed entry address. There are four kinds of redirection. The first comes out of reset. The other three come from interrupt sources: an external request pin and two timer overflow events. Each interrupt source has a pending flag that captures the rising edge of its request line. A pending source is serviced only when all of these hold:
- its own enable is set;
- the global enable is set;
- the call stack is not full;
- the fetch unit is not inside a two-cycle table-read sequence.

When a redirection happens the unit emits a one-cycle vector pulse together with the new program counter, the new bank and a source code. For an interrupt it also emits a push request that carries the return address and bank to be saved on the stack. The external entry always lies in bank 0. The two timer entries lie in whatever bank is current when the interrupt is taken. Taking an interrupt clears the global enable, which blocks nesting, and clears the pending flag of the source that was serviced.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst` is high every output is 0. On the first clock edge with `rst` low, `vec_take` pulses for one cycle with `vec_src`=0, `vec_pc`=0, `vec_bank`=0 and `push_req`=0.
- R2: Bit i of `pend` is set by a low-to-high transition of `irq_req[i]`. A request held high sets it only once. `pend_clr[i]` clears it. If a new rising edge and a clear for the same bit arrive in the same cycle, the bit ends up set. Bit 0 is the external source, bit 1 is timer 0 and bit 2 is timer 1.
- R3: Servicing the external source gives `vec_src`=1, `vec_pc`=0x004 and `vec_bank`=0.
- R4: Servicing timer 0 gives `vec_src`=2 and `vec_pc`=0x008, with `vec_bank` equal to `cur_bank` in the deciding cycle.
- R5: Servicing timer 1 gives `vec_src`=3 and `vec_pc`=0x00C, with `vec_bank` equal to `cur_bank` in the deciding cycle.
- R6: A source is serviced only if its `pend` bit and its `irq_en` bit are set, `gie` is 1, `stack_full` is 0 and `tbl_busy` is 0. A source that is suppressed keeps its pending bit.
- R7: When several eligible sources are pending at once, the external source wins, then timer 0, then timer 1.
- R8: Servicing an interrupt clears `gie` and the serviced source's `pend` bit, and leaves the other bits as they were. It also raises `push_req` with `push_pc`=`cur_pc` and `push_bank`=`cur_bank` taken from the deciding cycle.
- R9: `gie_wr` loads `gie` from `gie_wdata`. If an interrupt is serviced in the same cycle, the clear wins.
- R10: `vec_take` and `push_req` rise on the clock edge at which the servicing conditions hold and last exactly one cycle. A pending bit becomes visible on the edge that samples the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 3 | Request lines: external, timer 0, timer 1 |
| irq_en | input | 3 | Per-source enable bits |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| pend_clr | input | 3 | Software clear of the pending bits |
| stack_full | input | 1 | Call stack has no free entry |
| tbl_busy | input | 1 | Fetch unit is inside a table-read sequence |
| cur_pc | input | PC_W | Return address to be pushed |
| cur_bank | input | BANK_W | Currently selected bank |
| vec_take | output | 1 | One-cycle redirection pulse |
| vec_src | output | 2 | 0 reset, 1 external, 2 timer 0, 3 timer 1 |
| vec_pc | output | PC_W | New program counter |
| vec_bank | output | BANK_W | New bank |
| push_req | output | 1 | Push of the return address |
| push_pc | output | PC_W | Return address to push |
| push_bank | output | BANK_W | Return bank to push |
| gie | output | 1 | Global interrupt enable |
| pend | output | 3 | Pending flags |

## Verification
The hardest cases to reach from the ports are two same-cycle collisions. In the first, a service occurs in the very cycle that software rewrites the global enable. In the second, a request edge lands on the same cycle as a software clear of that bit. Directed sequences build each collision one register stage at a time. For the write collision, a source is held pending behind `tbl_busy`, and then the busy flag is dropped together with a `gie_wr`. For the clear collision, a request is lowered and then raised again in the cycle that carries `pend_clr`. A sweep covers every combination of pending pattern, enable mask, stack-full flag and table-busy flag, with the current bank varied along the way, and checks the selected vector against the arithmetic expected value.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int unsigned NUM_IRQ = 3;

  typedef enum logic [1:0] {
    SRC_BOOT = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR0 = 2'd2,
    SRC_TMR1 = 2'd3
  } vec_src_e;
endpackage

// File: rtl/ivu_pend_latch.sv
module ivu_pend_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] taken,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise = req[i] & ~req_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        req_q[i] <= req[i];
        // a fresh edge outranks both software clear and service
        pend[i]  <= (pend[i] & ~clr[i] & ~taken[i]) | rise;
      end
    end
  end
endmodule

// File: rtl/ivu_prio_arb.sv
module ivu_prio_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = elig[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | elig[i];
  end

  assign any = blocked[N];
endmodule

// File: rtl/ivu_vec_gen.sv
module ivu_vec_gen #(
  parameter int unsigned N           = 3,
  parameter int unsigned PC_W        = 13,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned VEC_SPACING = 4,
  parameter logic [N-1:0] BANK_REL   = 3'b110
) (
  input  logic [N-1:0]      grant,
  input  logic [BANK_W-1:0] cur_bank,
  output logic [PC_W-1:0]   pc,
  output logic [BANK_W-1:0] bank,
  output logic [1:0]        src
);
  logic [N-1:0][PC_W-1:0]   pc_term;
  logic [N-1:0][BANK_W-1:0] bank_term;
  logic [N-1:0][1:0]        src_term;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic [PC_W-1:0] ENTRY = PC_W'(VEC_SPACING * (i + 1));
    localparam logic [1:0]      CODE  = 2'(i + 1);
    assign pc_term[i]   = grant[i] ? ENTRY : '0;
    assign src_term[i]  = grant[i] ? CODE : 2'd0;
    if (BANK_REL[i]) begin : g_rel
      assign bank_term[i] = grant[i] ? cur_bank : '0;
    end else begin : g_abs
      assign bank_term[i] = '0;
    end
  end

  always_comb begin
    pc   = '0;
    bank = '0;
    src  = 2'd0;
    for (int k = 0; k < N; k++) begin
      pc   = pc | pc_term[k];
      bank = bank | bank_term[k];
      src  = src | src_term[k];
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int unsigned PC_W        = 13,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned VEC_SPACING = 4,
  parameter logic [2:0]  BANK_REL    = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        irq_req,
  input  logic [2:0]        irq_en,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic [2:0]        pend_clr,
  input  logic              stack_full,
  input  logic              tbl_busy,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [BANK_W-1:0] cur_bank,
  output logic              vec_take,
  output logic [1:0]        vec_src,
  output logic [PC_W-1:0]   vec_pc,
  output logic [BANK_W-1:0] vec_bank,
  output logic              push_req,
  output logic [PC_W-1:0]   push_pc,
  output logic [BANK_W-1:0] push_bank,
  output logic              gie,
  output logic [2:0]        pend
);
  import ivu_pkg::*;
  localparam int unsigned N = NUM_IRQ;

  logic              boot_q;
  logic [N-1:0]      elig;
  logic [N-1:0]      grant;
  logic              any_elig;
  logic              take_ok;
  logic [N-1:0]      taken;
  logic [PC_W-1:0]   gen_pc;
  logic [BANK_W-1:0] gen_bank;
  logic [1:0]        gen_src;

  ivu_pend_latch #(.N(N)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .req   (irq_req),
    .clr   (pend_clr),
    .taken (taken),
    .pend  (pend)
  );

  assign elig = pend & irq_en;

  ivu_prio_arb #(.N(N)) u_arb (
    .elig  (elig),
    .grant (grant),
    .any   (any_elig)
  );

  ivu_vec_gen #(
    .N(N), .PC_W(PC_W), .BANK_W(BANK_W),
    .VEC_SPACING(VEC_SPACING), .BANK_REL(BANK_REL)
  ) u_gen (
    .grant    (grant),
    .cur_bank (cur_bank),
    .pc       (gen_pc),
    .bank     (gen_bank),
    .src      (gen_src)
  );

  assign take_ok = any_elig & gie & ~stack_full & ~tbl_busy & ~boot_q;
  assign taken   = grant & {N{take_ok}};

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q    <= 1'b1;
      vec_take  <= 1'b0;
      vec_src   <= SRC_BOOT;
      vec_pc    <= '0;
      vec_bank  <= '0;
      push_req  <= 1'b0;
      push_pc   <= '0;
      push_bank <= '0;
      gie       <= 1'b0;
    end else begin
      boot_q   <= 1'b0;
      vec_take <= boot_q | take_ok;
      push_req <= take_ok;
      if (boot_q) begin
        vec_src  <= SRC_BOOT;
        vec_pc   <= '0;
        vec_bank <= '0;
      end else if (take_ok) begin
        vec_src   <= gen_src;
        vec_pc    <= gen_pc;
        vec_bank  <= gen_bank;
        push_pc   <= cur_pc;
        push_bank <= cur_bank;
      end
      if (take_ok)     gie <= 1'b0;
      else if (gie_wr) gie <= gie_wdata;
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int unsigned PC_W        = 13,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned VEC_SPACING = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        irq_en,
  input logic              stack_full,
  input logic              tbl_busy,
  input logic [BANK_W-1:0] cur_bank,
  input logic              vec_take,
  input logic [1:0]        vec_src,
  input logic [PC_W-1:0]   vec_pc,
  input logic [BANK_W-1:0] vec_bank,
  input logic              push_req,
  input logic              gie,
  input logic [2:0]        pend
);
  assert_boot_vector_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (vec_take && vec_src == 2'd0 && vec_pc == '0 && vec_bank == '0 && !push_req));

  assert_ext_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (push_req && vec_src == 2'd1) |-> (vec_pc == PC_W'(VEC_SPACING) && vec_bank == '0));

  assert_tmr0_bank_R4: assert property (@(posedge clk) disable iff (rst)
    (push_req && vec_src == 2'd2) |-> (vec_pc == PC_W'(2*VEC_SPACING) && vec_bank == $past(cur_bank)));

  assert_tmr1_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (push_req && vec_src == 2'd3) |-> (vec_pc == PC_W'(3*VEC_SPACING) && vec_bank == $past(cur_bank)));

  assert_gating_R6: assert property (@(posedge clk) disable iff (rst)
    push_req |-> ($past(gie) && !$past(stack_full) && !$past(tbl_busy)));

  assert_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (push_req && vec_src == 2'd3) |-> !($past(pend[0] & irq_en[0]) || $past(pend[1] & irq_en[1])));

  assert_gie_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    push_req |-> (!gie && vec_take));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    push_req |=> !push_req);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .PC_W(PC_W), .BANK_W(BANK_W), .VEC_SPACING(VEC_SPACING)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_en     (irq_en),
  .stack_full (stack_full),
  .tbl_busy   (tbl_busy),
  .cur_bank   (cur_bank),
  .vec_take   (vec_take),
  .vec_src    (vec_src),
  .vec_pc     (vec_pc),
  .vec_bank   (vec_bank),
  .push_req   (push_req),
  .gie        (gie),
  .pend       (pend)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 13;
  localparam int BANK_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        irq_req = '0;
  logic [2:0]        irq_en = '0;
  logic              gie_wr = 1'b0;
  logic              gie_wdata = 1'b0;
  logic [2:0]        pend_clr = '0;
  logic              stack_full = 1'b0;
  logic              tbl_busy = 1'b0;
  logic [PC_W-1:0]   cur_pc = '0;
  logic [BANK_W-1:0] cur_bank = '0;
  logic              vec_take;
  logic [1:0]        vec_src;
  logic [PC_W-1:0]   vec_pc;
  logic [BANK_W-1:0] vec_bank;
  logic              push_req;
  logic [PC_W-1:0]   push_pc;
  logic [BANK_W-1:0] push_bank;
  logic              gie;
  logic [2:0]        pend;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_unit u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .pend_clr(pend_clr),
    .stack_full(stack_full), .tbl_busy(tbl_busy), .cur_pc(cur_pc),
    .cur_bank(cur_bank), .vec_take(vec_take), .vec_src(vec_src),
    .vec_pc(vec_pc), .vec_bank(vec_bank), .push_req(push_req),
    .push_pc(push_pc), .push_bank(push_bank), .gie(gie), .pend(pend)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiesce();
    irq_req = '0; irq_en = '0; stack_full = 0; tbl_busy = 0;
    gie_wr = 1; gie_wdata = 0; pend_clr = 3'b111;
    cyc();
    gie_wr = 0; pend_clr = '0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then boot vector
    cyc(); cyc();
    chk("R1", "vec_take in reset", int'(vec_take), 0);
    chk("R1", "gie in reset", int'(gie), 0);
    chk("R1", "pend in reset", int'(pend), 0);
    rst = 0;
    cyc();
    chk("R1", "boot take", int'(vec_take), 1);
    chk("R1", "boot src", int'(vec_src), 0);
    chk("R1", "boot pc", int'(vec_pc), 0);
    chk("R1", "boot bank", int'(vec_bank), 0);
    chk("R1", "boot push", int'(push_req), 0);
    cyc();
    chk("R10", "boot pulse width", int'(vec_take), 0);

    // R2: held level sets once, clear sticks while level stays high
    quiesce();
    irq_req = 3'b001;
    cyc();
    chk("R2", "edge sets pend", int'(pend), 1);
    pend_clr = 3'b001;
    cyc();
    pend_clr = '0;
    chk("R2", "clear while high", int'(pend), 0);
    cyc(); cyc();
    chk("R2", "held level no reset", int'(pend), 0);
    irq_req = 3'b000;
    cyc();
    irq_req = 3'b001; pend_clr = 3'b001;
    cyc();
    pend_clr = '0;
    chk("R2", "rise beats clear", int'(pend), 1);
    irq_req = '0;

    // R9: take collides with software write of gie
    quiesce();
    irq_req = 3'b001;
    cyc();
    irq_req = '0; irq_en = 3'b001; tbl_busy = 1;
    gie_wr = 1; gie_wdata = 1;
    cyc();
    gie_wr = 0;
    cyc();
    chk("R6", "table window blocks", int'(vec_take), 0);
    chk("R6", "pend kept in window", int'(pend), 1);
    tbl_busy = 0; gie_wr = 1; gie_wdata = 1;
    cyc();
    gie_wr = 0;
    chk("R9", "take beats gie write", int'(gie), 0);
    chk("R9", "take occurred", int'(push_req), 1);

    // R6/R10: stall on full stack, then release
    quiesce();
    irq_req = 3'b100; irq_en = 3'b100; stack_full = 1;
    cur_bank = 3'd5; cur_pc = 13'h0abc;
    gie_wr = 1; gie_wdata = 1;
    cyc();
    irq_req = '0; gie_wr = 0;
    cyc(); cyc(); cyc();
    chk("R6", "full stack blocks", int'(vec_take), 0);
    chk("R6", "pend kept when full", int'(pend), 4);
    stack_full = 0;
    cyc();
    chk("R10", "take after release", int'(vec_take), 1);
    chk("R5", "tmr1 pc", int'(vec_pc), 12);
    chk("R5", "tmr1 bank", int'(vec_bank), 5);
    chk("R8", "push pc", int'(push_pc), 13'h0abc);
    cyc();
    chk("R10", "take one cycle", int'(vec_take), 0);

    // sweep: pending pattern x enables x stack_full x tbl_busy
    for (int c = 0; c < 256; c++) begin
      logic [2:0] p, en, el, gr, exp_pend;
      logic sf, tb, exp_take;
      int g;
      p = c[2:0]; en = c[5:3]; sf = c[6]; tb = c[7];
      quiesce();
      irq_req = p;
      cyc();
      irq_req = '0;
      chk("R2", "pattern latched", int'(pend), int'(p));
      irq_en = en; stack_full = sf; tbl_busy = tb;
      cur_pc = PC_W'(13'h1000 + c);
      cur_bank = BANK_W'(c * 3 + 1);
      gie_wr = 1; gie_wdata = 1;
      cyc();
      gie_wr = 0;
      cyc();
      el = p & en;
      g = -1;
      for (int k = 2; k >= 0; k--) if (el[k]) g = k;
      exp_take = (g >= 0) && !sf && !tb;
      gr = exp_take ? (3'b001 << g) : 3'b000;
      exp_pend = p & ~gr;
      chk("R6", "take gating", int'(vec_take), int'(exp_take));
      chk("R8", "pend after decision", int'(pend), int'(exp_pend));
      chk("R8", "gie after decision", int'(gie), exp_take ? 0 : 1);
      if (exp_take) begin
        chk("R7", "priority src", int'(vec_src), g + 1);
        chk(g == 0 ? "R3" : (g == 1 ? "R4" : "R5"), "vector pc", int'(vec_pc), 4 * (g + 1));
        chk(g == 0 ? "R3" : (g == 1 ? "R4" : "R5"), "vector bank", int'(vec_bank),
            g == 0 ? 0 : int'(cur_bank));
        chk("R8", "push pc", int'(push_pc), int'(cur_pc));
        chk("R8", "push bank", int'(push_bank), int'(cur_bank));
      end
      cyc();
      chk("R10", "pulse ends", int'(push_req), 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule